// File: doc/BRIEF.md
# Parity Stripe Block Read Engine

This block serves read requests for logical blocks stored across a small disk array laid out in parity stripes. A request carries a logical block number. The block turns that number into a target disk and a stripe row. It sends one read command to that disk and stages the returned words in an internal block buffer. If the target read completes cleanly, the buffer is streamed out and the response reports a plain success.

If the target disk reports an error, the block rebuilds the lost data. It reads the same row from every other disk in the array, one disk at a time. The first block to arrive overwrites the buffer, which has the same effect as clearing it to zero and then XORing in the first block. Each later block is XORed into the stored words one word per cycle. If any of these other disks also reports an error, the data cannot be recovered. The request then ends with a failure response and no data.

The engine issues commands strictly one after another. As a result, no disk ever has more than one read outstanding.

Top module: `stripe_rebuild_reader`

## Requirements
- R1: The target disk index is the request block number modulo DATA_DISKS (4), and the row driven on `dsk_row` with every command is the block number divided by DATA_DISKS. The first command of every request goes to the target disk.
- R2: When the target read completes without error, the output words equal the target disk's block in order. `resp_status` is 0 (ok), and exactly one read command is issued for the request.
- R3: When the target read reports an error, one command is issued to each of the other NUM_DISKS-1 disks. All of them use the same row, they go in ascending disk index order, and each disk is read exactly once.
- R4: A rebuilt response carries `resp_status` 1 (rebuilt). Each output word is the XOR of the corresponding words of all non-target disks at that row. No word that the failing target returned reaches the output.
- R5: An error from any disk during a rebuild ends the request with `resp_status` 2 (failed). In that case `resp_done` pulses with no `out_valid` word, and no further command is issued after the erroring disk.
- R6: At most one bit of `dsk_cmd` is high in any cycle. No command goes to a disk whose previous read has not yet signalled `dsk_done`.
- R7: `dsk_vld` and `dsk_data` from any disk other than the one currently being read are ignored and never alter the output.
- R8: A successful or rebuilt response streams exactly WORDS words, from word 0 upward, on consecutive cycles. `out_last` marks the final word, and `resp_done` is high in that same cycle. `req_ready` is low from the cycle after a request is accepted until the response has completed.
- R9: After reset, `req_ready` is 1, and `dsk_cmd`, `out_valid`, `out_last` and `resp_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine idle and accepting a request |
| req_block | input | BLK_W | Logical block number |
| dsk_cmd | output | NUM_DISKS | One-cycle read command, one bit per disk |
| dsk_row | output | ROW_W | Stripe row for the command |
| dsk_vld | input | NUM_DISKS | Data word valid, one bit per disk |
| dsk_data | input | NUM_DISKS*DATA_W | Data words, disk i at bits [i*DATA_W +: DATA_W] |
| dsk_done | input | NUM_DISKS | Read completion pulse per disk |
| dsk_err | input | NUM_DISKS | Error flag, qualified by `dsk_done` |
| out_valid | output | 1 | Output word valid |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Final output word |
| resp_done | output | 1 | Response pulse |
| resp_status | output | 2 | 0 ok, 1 rebuilt, 2 failed; valid with `resp_done` |

## Verification
The assertions take the following for granted about the disk side:
- A disk pulses `dsk_done` only while it holds an outstanding command.
- A disk that completes cleanly has delivered exactly WORDS words first.
- The completion pulse comes at least one cycle after the last word.
- The output side never stalls.

The bench disk models wake only on their own command bit. Each waits a latency that differs per disk, streams a full block, and only then raises completion with its error flag. An erroring disk still streams a block of corrupted words. The interference pattern toggles only the valid and data lines of idle disks, never their completion lines, so the completion contract holds throughout.

// File: rtl/srr_pkg.sv
package srr_pkg;

   typedef enum logic [1:0] {
      RSP_OK      = 2'd0,
      RSP_REBUILT = 2'd1,
      RSP_FAILED  = 2'd2
   } srr_status_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_CMD,
      SQ_WAIT,
      SQ_OUT,
      SQ_DONE
   } srr_state_e;

endpackage

// File: rtl/srr_addr_map.sv
module srr_addr_map #(
   parameter int BLK_W      = 16,
   parameter int DATA_DISKS = 4,
   parameter int DISK_W     = 3,
   parameter int ROW_W      = 16
) (
   input  logic [BLK_W-1:0]  blk,
   output logic [DISK_W-1:0] disk,
   output logic [ROW_W-1:0]  row
);

   localparam bit IS_POW2 = (DATA_DISKS & (DATA_DISKS - 1)) == 0;

   generate
      if (IS_POW2) begin : g_shift
         localparam int SH = $clog2(DATA_DISKS);
         assign disk = DISK_W'(blk[SH-1:0]);
         assign row  = ROW_W'(blk >> SH);
      end else begin : g_divide
         assign disk = DISK_W'(blk % BLK_W'(DATA_DISKS));
         assign row  = ROW_W'(blk / BLK_W'(DATA_DISKS));
      end
   endgenerate

endmodule

// File: rtl/srr_acc_buffer.sv
module srr_acc_buffer #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 1024,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_xor,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [WORDS];
   logic [DATA_W-1:0] rd_q;
   logic              s1_vld;
   logic              s1_xor;
   logic [ADDR_W-1:0] s1_addr;
   logic [DATA_W-1:0] s1_data;
   logic [ADDR_W-1:0] port_addr;

   // one read port: accumulation owns it while words arrive
   assign port_addr = acc_en ? acc_addr : rd_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_xor  <= 1'b0;
         s1_addr <= '0;
         s1_data <= '0;
      end else begin
         s1_vld  <= acc_en;
         s1_xor  <= acc_xor;
         s1_addr <= acc_addr;
         s1_data <= acc_data;
      end
   end

   // stage 1 reads the old word, stage 2 writes the merged word
   always_ff @(posedge clk) begin
      rd_q <= mem[port_addr];
      if (s1_vld) begin
         mem[s1_addr] <= s1_xor ? (rd_q ^ s1_data) : s1_data;
      end
   end

   assign rd_data = rd_q;

endmodule

// File: rtl/srr_sequencer.sv
module srr_sequencer
   import srr_pkg::*;
#(
   parameter int NUM_DISKS = 5,
   parameter int DISK_W    = 3,
   parameter int ROW_W     = 16,
   parameter int DATA_W    = 32,
   parameter int WORDS     = 1024,
   parameter int ADDR_W    = 10
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [DISK_W-1:0]           req_disk,
   input  logic [ROW_W-1:0]            req_row,
   output logic [NUM_DISKS-1:0]        dsk_cmd,
   output logic [ROW_W-1:0]            dsk_row,
   input  logic [NUM_DISKS-1:0]        dsk_vld,
   input  logic [NUM_DISKS*DATA_W-1:0] dsk_data,
   input  logic [NUM_DISKS-1:0]        dsk_done,
   input  logic [NUM_DISKS-1:0]        dsk_err,
   output logic                        acc_en,
   output logic                        acc_xor,
   output logic [ADDR_W-1:0]           acc_addr,
   output logic [DATA_W-1:0]           acc_data,
   output logic [ADDR_W-1:0]           rd_addr,
   output logic                        out_valid,
   output logic                        out_last,
   output logic                        resp_done,
   output logic [1:0]                  resp_status
);

   localparam int          IW       = DISK_W + 1;
   localparam logic [IW-1:0] LIMIT  = IW'(NUM_DISKS);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

   srr_state_e        state;
   srr_status_e       status_q;
   logic [DISK_W-1:0] cur;
   logic [DISK_W-1:0] tgt;
   logic [ROW_W-1:0]  row_q;
   logic              rebuild;
   logic              first_q;
   logic [ADDR_W-1:0] wcnt;
   logic [ADDR_W-1:0] ocnt;
   logic              out_v_q;
   logic              out_l_q;

   logic [DATA_W-1:0] lane [NUM_DISKS];
   logic              sel_vld;
   logic              sel_done;
   logic              sel_err;
   logic [IW-1:0]     nx_first;
   logic [IW-1:0]     nx_next;

   generate
      for (genvar i = 0; i < NUM_DISKS; i++) begin : g_lane
         assign lane[i] = dsk_data[i*DATA_W +: DATA_W];
      end
   endgenerate

   function automatic logic [IW-1:0] skip_tgt(input logic [IW-1:0] x,
                                              input logic [DISK_W-1:0] t);
      return (x == {1'b0, t}) ? x + 1'b1 : x;
   endfunction

   assign sel_vld  = dsk_vld[cur];
   assign sel_done = dsk_done[cur];
   assign sel_err  = dsk_err[cur];
   assign nx_first = skip_tgt('0, tgt);
   assign nx_next  = skip_tgt({1'b0, cur} + 1'b1, tgt);

   assign acc_en   = (state == SQ_WAIT) && sel_vld;
   assign acc_xor  = rebuild && !first_q;
   assign acc_addr = wcnt;
   assign acc_data = lane[cur];
   assign rd_addr  = ocnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         status_q <= RSP_OK;
         cur      <= '0;
         tgt      <= '0;
         row_q    <= '0;
         rebuild  <= 1'b0;
         first_q  <= 1'b1;
         wcnt     <= '0;
         ocnt     <= '0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (req_valid) begin
                  tgt     <= req_disk;
                  cur     <= req_disk;
                  row_q   <= req_row;
                  rebuild <= 1'b0;
                  first_q <= 1'b1;
                  state   <= SQ_CMD;
               end
            end
            SQ_CMD: begin
               wcnt  <= '0;
               state <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (acc_en) wcnt <= wcnt + 1'b1;
               if (sel_done) begin
                  if (!rebuild) begin
                     if (!sel_err) begin
                        status_q <= RSP_OK;
                        ocnt     <= '0;
                        state    <= SQ_OUT;
                     end else begin
                        rebuild <= 1'b1;
                        first_q <= 1'b1;
                        cur     <= nx_first[DISK_W-1:0];
                        state   <= SQ_CMD;
                     end
                  end else if (sel_err) begin
                     status_q <= RSP_FAILED;
                     state    <= SQ_DONE;
                  end else begin
                     first_q <= 1'b0;
                     if (nx_next >= LIMIT) begin
                        status_q <= RSP_REBUILT;
                        ocnt     <= '0;
                        state    <= SQ_OUT;
                     end else begin
                        cur   <= nx_next[DISK_W-1:0];
                        state <= SQ_CMD;
                     end
                  end
               end
            end
            SQ_OUT: begin
               ocnt <= ocnt + 1'b1;
               if (ocnt == LAST_ADDR) state <= SQ_DONE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v_q <= 1'b0;
         out_l_q <= 1'b0;
      end else begin
         out_v_q <= (state == SQ_OUT);
         out_l_q <= (state == SQ_OUT) && (ocnt == LAST_ADDR);
      end
   end

   assign req_ready   = (state == SQ_IDLE);
   assign dsk_cmd     = (state == SQ_CMD) ? (NUM_DISKS'(1) << cur) : '0;
   assign dsk_row     = row_q;
   assign out_valid   = out_v_q;
   assign out_last    = out_l_q;
   assign resp_done   = (state == SQ_DONE);
   assign resp_status = status_q;

endmodule

// File: rtl/stripe_rebuild_reader.sv
module stripe_rebuild_reader #(
   parameter int BLK_W      = 16,
   parameter int DATA_DISKS = 4,
   parameter int DATA_W     = 32,
   parameter int WORDS      = 1024,
   localparam int NUM_DISKS = DATA_DISKS + 1,
   localparam int DISK_W    = $clog2(NUM_DISKS),
   localparam int ROW_W     = BLK_W,
   localparam int ADDR_W    = $clog2(WORDS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [BLK_W-1:0]            req_block,
   output logic [NUM_DISKS-1:0]        dsk_cmd,
   output logic [ROW_W-1:0]            dsk_row,
   input  logic [NUM_DISKS-1:0]        dsk_vld,
   input  logic [NUM_DISKS*DATA_W-1:0] dsk_data,
   input  logic [NUM_DISKS-1:0]        dsk_done,
   input  logic [NUM_DISKS-1:0]        dsk_err,
   output logic                        out_valid,
   output logic [DATA_W-1:0]           out_data,
   output logic                        out_last,
   output logic                        resp_done,
   output logic [1:0]                  resp_status
);

   generate
      if (DATA_DISKS < 2) begin : g_bad_disks
         $error("DATA_DISKS must be at least 2");
      end
      if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("WORDS must be a power of two of at least 2");
      end
      if (BLK_W < 2) begin : g_bad_blk
         $error("BLK_W must be at least 2");
      end
   endgenerate

   logic [DISK_W-1:0] map_disk;
   logic [ROW_W-1:0]  map_row;
   logic              acc_en;
   logic              acc_xor;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] acc_data;
   logic [ADDR_W-1:0] rd_addr;

   srr_addr_map #(
      .BLK_W      (BLK_W),
      .DATA_DISKS (DATA_DISKS),
      .DISK_W     (DISK_W),
      .ROW_W      (ROW_W)
   ) u_map (
      .blk  (req_block),
      .disk (map_disk),
      .row  (map_row)
   );

   srr_sequencer #(
      .NUM_DISKS (NUM_DISKS),
      .DISK_W    (DISK_W),
      .ROW_W     (ROW_W),
      .DATA_W    (DATA_W),
      .WORDS     (WORDS),
      .ADDR_W    (ADDR_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_disk    (map_disk),
      .req_row     (map_row),
      .dsk_cmd     (dsk_cmd),
      .dsk_row     (dsk_row),
      .dsk_vld     (dsk_vld),
      .dsk_data    (dsk_data),
      .dsk_done    (dsk_done),
      .dsk_err     (dsk_err),
      .acc_en      (acc_en),
      .acc_xor     (acc_xor),
      .acc_addr    (acc_addr),
      .acc_data    (acc_data),
      .rd_addr     (rd_addr),
      .out_valid   (out_valid),
      .out_last    (out_last),
      .resp_done   (resp_done),
      .resp_status (resp_status)
   );

   srr_acc_buffer #(
      .DATA_W (DATA_W),
      .WORDS  (WORDS),
      .ADDR_W (ADDR_W)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_en   (acc_en),
      .acc_xor  (acc_xor),
      .acc_addr (acc_addr),
      .acc_data (acc_data),
      .rd_addr  (rd_addr),
      .rd_data  (out_data)
   );

endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
   parameter int NUM_DISKS = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic [NUM_DISKS-1:0] dsk_cmd,
   input logic [NUM_DISKS-1:0] dsk_done,
   input logic                 out_valid,
   input logic                 out_last,
   input logic                 resp_done,
   input logic [1:0]           resp_status
);

   localparam int CW = $clog2(NUM_DISKS + 1) + 1;

   logic [NUM_DISKS-1:0] outst;
   logic [CW-1:0]        cmd_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst   <= '0;
         cmd_cnt <= '0;
      end else begin
         outst <= (outst | dsk_cmd) & ~dsk_done;
         if (req_valid && req_ready) cmd_cnt <= '0;
         else if (|dsk_cmd)          cmd_cnt <= cmd_cnt + 1'b1;
      end
   end

   p_single_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dsk_cmd));

   p_no_double_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dsk_cmd & outst) == '0);

   p_ok_one_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_done && resp_status == 2'd0) |-> (cmd_cnt == CW'(1)));

   p_rebuild_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_done && resp_status == 2'd1) |-> (cmd_cnt == CW'(NUM_DISKS)));

   p_status_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done |-> (resp_status != 2'd3));

   p_fail_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_done && resp_status == 2'd2) |-> !out_valid);

   p_last_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (out_valid && resp_done));

   p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

bind stripe_rebuild_reader srr_checker #(
   .NUM_DISKS (NUM_DISKS)
) u_srr_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .dsk_cmd     (dsk_cmd),
   .dsk_done    (dsk_done),
   .out_valid   (out_valid),
   .out_last    (out_last),
   .resp_done   (resp_done),
   .resp_status (resp_status)
);

// File: tb/stripe_rebuild_reader_tb.sv
module stripe_rebuild_reader_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ND         = 5;
   localparam int DW         = 32;
   localparam int WORDS      = 1024;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [15:0]      req_block = '0;
   logic [ND-1:0]    dsk_cmd;
   logic [15:0]      dsk_row;
   logic [ND-1:0]    dsk_vld;
   logic [ND*DW-1:0] dsk_data;
   logic [ND-1:0]    dsk_done;
   logic [ND-1:0]    dsk_err;
   logic             out_valid;
   logic [DW-1:0]    out_data;
   logic             out_last;
   logic             resp_done;
   logic [1:0]       resp_status;

   always #(CLK_PERIOD/2) clk = ~clk;

   stripe_rebuild_reader u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_block(req_block), .dsk_cmd(dsk_cmd), .dsk_row(dsk_row),
      .dsk_vld(dsk_vld), .dsk_data(dsk_data), .dsk_done(dsk_done),
      .dsk_err(dsk_err), .out_valid(out_valid), .out_data(out_data),
      .out_last(out_last), .resp_done(resp_done), .resp_status(resp_status)
   );

   int          total = 0;
   int          bad   = 0;
   logic [ND-1:0] err_mask = '0;
   logic        noise_en = 1'b0;

   // expectation state
   int          exp_mode = 0;   // 0 plain, 1 rebuilt
   int          exp_tgt  = 0;
   int          exp_row  = 0;

   // monitor state
   int          wcount, word_bad, last_bad, cmdn, row_bad;
   int          first_act, first_exp;
   int          cmd_disk [8];
   bit          done_seen, done_last;
   int          got_status;

   function automatic logic [31:0] dword(int d, int row, int w);
      return (32'(d + 1) * 32'h2F6B_1A09) ^ (32'(row) * 32'h0001_0021) ^ (32'(w) * 32'h0000_0107);
   endfunction

   function automatic logic [31:0] exp_word(int w);
      logic [31:0] acc;
      if (exp_mode == 0) return dword(exp_tgt, exp_row, w);
      acc = '0;
      for (int d = 0; d < ND; d++) if (d != exp_tgt) acc ^= dword(d, exp_row, w);
      return acc;
   endfunction

   // disk models
   for (genvar g = 0; g < ND; g++) begin : g_disk
      logic        v = 1'b0, dn = 1'b0, er = 1'b0, busy = 1'b0;
      logic [31:0] dat = '0;
      assign dsk_vld[g]          = v | (noise_en & ~busy);
      assign dsk_data[g*DW +: DW] = busy ? dat : (32'hBAD0_0000 | 32'(g));
      assign dsk_done[g]         = dn;
      assign dsk_err[g]          = er;
      initial begin
         forever begin
            @(negedge clk);
            if (dsk_cmd[g]) begin
               int row;
               row  = int'(dsk_row);
               busy = 1'b1;
               repeat (2 + g) @(negedge clk);
               for (int w = 0; w < WORDS; w++) begin
                  v   = 1'b1;
                  dat = err_mask[g] ? (dword(g, row, w) ^ 32'hFFFF_0000) : dword(g, row, w);
                  @(negedge clk);
               end
               v  = 1'b0;
               dn = 1'b1;
               er = err_mask[g];
               @(negedge clk);
               dn   = 1'b0;
               er   = 1'b0;
               busy = 1'b0;
            end
         end
      end
   end

   // output and command monitor, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (out_data !== exp_word(wcount)) begin
               if (word_bad == 0) begin
                  first_act = int'(out_data);
                  first_exp = int'(exp_word(wcount));
               end
               word_bad++;
            end
            if (out_last && wcount != WORDS - 1) last_bad++;
            wcount++;
         end
         if (resp_done) begin
            done_seen  = 1'b1;
            done_last  = out_last;
            got_status = int'(resp_status);
         end
         if (|dsk_cmd) begin
            for (int i = 0; i < ND; i++) if (dsk_cmd[i] && cmdn < 8) cmd_disk[cmdn] = i;
            if (int'(dsk_row) != exp_row) row_bad++;
            cmdn++;
         end
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_read(int blk, logic [ND-1:0] emask, bit noise, string tag);
      int exp_cmds [8];
      int exp_n, exp_status, t, order_bad;
      bit failed;
      string rq;
      exp_tgt  = blk % 4;
      exp_row  = blk / 4;
      exp_mode = emask[exp_tgt] ? 1 : 0;
      err_mask = emask;
      noise_en = noise;
      wcount = 0; word_bad = 0; last_bad = 0; cmdn = 0; row_bad = 0;
      first_act = 0; first_exp = 0;
      done_seen = 1'b0; done_last = 1'b0; got_status = -1;
      // expected command sequence
      exp_n = 1;
      exp_cmds[0] = exp_tgt;
      failed = 1'b0;
      if (emask[exp_tgt]) begin
         for (int d = 0; d < ND; d++) begin
            if (d != exp_tgt && !failed) begin
               exp_cmds[exp_n] = d;
               exp_n++;
               if (emask[d]) failed = 1'b1;
            end
         end
      end
      exp_status = !emask[exp_tgt] ? 0 : (failed ? 2 : 1);
      rq = (exp_status == 0) ? "R2" : ((exp_status == 1) ? "R3" : "R5");
      @(negedge clk);
      req_valid = 1'b1;
      req_block = 16'(blk);
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!done_seen && t < 30000) begin
         @(negedge clk);
         t++;
      end
      chk(done_seen, tag, "response seen", int'(done_seen), 1);
      @(negedge clk);
      @(negedge clk);
      noise_en = 1'b0;
      chk(cmd_disk[0] == exp_tgt, "R1", {tag, " first command disk"}, cmd_disk[0], exp_tgt);
      chk(row_bad == 0, "R1", {tag, " command row"}, row_bad, 0);
      chk(cmdn == exp_n, rq, {tag, " command count"}, cmdn, exp_n);
      order_bad = 0;
      for (int i = 0; i < exp_n && i < 8; i++) if (cmd_disk[i] != exp_cmds[i]) order_bad++;
      chk(order_bad == 0, "R3", {tag, " command order"}, order_bad, 0);
      chk(got_status == exp_status, (exp_status == 1) ? "R4" : rq, {tag, " status"}, got_status, exp_status);
      chk(wcount == (failed ? 0 : WORDS), failed ? "R5" : "R8", {tag, " word count"}, wcount, failed ? 0 : WORDS);
      chk(word_bad == 0, (exp_status == 1) ? (noise ? "R7" : "R4") : (noise ? "R7" : "R2"),
          {tag, " data words"}, first_act, first_exp);
      chk(last_bad == 0 && (failed || done_last), "R8", {tag, " last marker"}, last_bad, 0);
      chk(req_ready == 1'b1, "R8", {tag, " ready after response"}, int'(req_ready), 1);
   endtask

   task automatic t_reset();
      chk(req_ready == 1'b1, "R9", "reset ready", int'(req_ready), 1);
      chk(dsk_cmd == '0, "R9", "reset command", int'(dsk_cmd), 0);
      chk(!out_valid && !out_last, "R9", "reset output", int'(out_valid), 0);
      chk(resp_done == 1'b0, "R9", "reset done", int'(resp_done), 0);
   endtask

   task automatic t_plain_reads();
      run_read(0, 5'b00000, 1'b0, "R2 plain block 0");
      run_read(16'h0107, 5'b00000, 1'b0, "R2 plain disk3");
   endtask

   task automatic t_rebuilds();
      run_read(8, 5'b00001, 1'b0, "R4 rebuild disk0");
      run_read(16'h0456, 5'b00100, 1'b0, "R4 rebuild disk2");
   endtask

   task automatic t_rebuild_noise();
      run_read(16'h1237, 5'b01000, 1'b1, "R7 rebuild disk3 noisy");
      run_read(16'h0021, 5'b00000, 1'b1, "R7 plain disk1 noisy");
   endtask

   task automatic t_double_fault();
      run_read(16'h0035, 5'b10010, 1'b0, "R5 fault on last disk");
      run_read(16'h0040, 5'b00011, 1'b0, "R5 fault on first helper");
      run_read(16'h0042, 5'b00000, 1'b0, "R2 read after failure");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain_reads();
      t_rebuilds();
      t_rebuild_noise();
      t_double_fault();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule